// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Capture

This block watches inbound message-signalled interrupt writes and turns each one that lands on a programmed capture address into a pending flag for one of 32 vectors. Software programs the capture address as two 32-bit words, a low word whose bit 0 turns capture on and a high word. It reads and clears the pending flags and masks vectors through a per-vector enable register.

A pending flag that is also enabled raises the interrupt. Two interrupt request lines carry that same summary so that two interrupt controller inputs can be wired to it. Pending flags keep latching while their vector is masked, so unmasking a vector that already has a message waiting raises the interrupt at once.

The register port is a simple select/write-strobe interface with a combinational read path. The inbound message port presents one write per cycle as a valid flag, a 64-bit address and a data word.

Top module: `msi_capture_ctrl`

## Requirements
- R1: There are exactly 32 vectors. Register select 0 is the low capture word, 1 the high capture word, 2 the pending register (bit n = vector n), 3 the enable register (bit n = vector n). Reads return current contents. After reset all four read 0 and both interrupt lines are low.
- R2: A register write to select 2 clears each pending bit whose write-data bit is 1, visible from the cycle after the write edge. Bits written 0 keep their value.
- R3: Bit 0 of the low capture word is the capture-enable flag and reads back as written. The address compared is the low word with bit 0 forced to 0, so an inbound address with bit 0 set never matches.
- R4: An inbound write matches only when bits 63:32 of its address equal the high capture word and bits 31:0 equal the masked low word.
- R5: A matching inbound write sets the pending bit indexed by its data value. The bit reads 1 from the cycle after the capture edge.
- R6: An inbound write whose data value is 32 or above sets no pending bit.
- R7: No pending bit is set while the capture-enable flag is 0 or the inbound valid flag is low.
- R8: Both interrupt outputs are identical. They are high exactly when some pending bit and the enable bit at the same position are both 1.
- R9: When a clear write and a matching arrival hit the same pending bit in one cycle, the bit stays set.
- R10: A pending bit latches while its enable bit is 0. The interrupt rises in the cycle after the edge that writes its enable bit to 1.
- R11: Writing 0 to the enable register drops both interrupt outputs from the next cycle, whatever is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 low addr, 1 high addr, 2 pending, 3 enable) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| msg_valid | input | 1 | Inbound write valid |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data (vector number) |
| irq_a | output | 1 | Interrupt request, first copy |
| irq_b | output | 1 | Interrupt request, second copy |

## Verification
A software clear of the pending register and a matching inbound write can hit the same flag on the same clock edge. The bench provokes this directly by leaving a vector pending and then issuing a write-one clear to it together with a matching message for the same vector. It expects the flag to read 1 afterwards. The random phase mixes clear writes with arrivals on overlapping vectors, and a reference model that applies clear before set judges every such collision through the pending readback and both interrupt lines.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;
   typedef enum logic [1:0] {
      SEL_CAP_LO = 2'd0,
      SEL_CAP_HI = 2'd1,
      SEL_PEND   = 2'd2,
      SEL_ENABLE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/msi_cap_regs.sv
`timescale 1ns/1ps
// Capture address words and per-vector enable register.
module msi_cap_regs #(
   parameter int REG_W   = 32,
   parameter int NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [1:0]         sel,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   cap_lo,
   output logic [REG_W-1:0]   cap_hi,
   output logic [NUM_VEC-1:0] en
);
   import msi_cap_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_lo <= '0;
         cap_hi <= '0;
         en     <= '0;
      end else if (wr) begin
         case (reg_sel_e'(sel))
            SEL_CAP_LO: cap_lo <= wdata;
            SEL_CAP_HI: cap_hi <= wdata;
            SEL_ENABLE: en     <= wdata[NUM_VEC-1:0];
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/msi_cap_match.sv
`timescale 1ns/1ps
// Address match and one-hot vector decode of an inbound write.
module msi_cap_match #(
   parameter int REG_W   = 32,
   parameter int DATA_W  = 32,
   parameter int NUM_VEC = 32
) (
   input  logic                 msg_valid,
   input  logic [2*REG_W-1:0]   msg_addr,
   input  logic [DATA_W-1:0]    msg_data,
   input  logic [REG_W-1:0]     cap_lo,
   input  logic [REG_W-1:0]     cap_hi,
   output logic [NUM_VEC-1:0]   set_vec
);
   logic [2*REG_W-1:0] target;
   logic               hit;

   assign target = {cap_hi, cap_lo[REG_W-1:1], 1'b0};
   assign hit    = msg_valid && cap_lo[0] && (msg_addr == target);

   for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
      assign set_vec[i] = hit && (msg_data == DATA_W'(i));
   end
endmodule

// File: rtl/msi_cap_pending.sv
`timescale 1ns/1ps
// Per-vector pending flags: arrival has priority over write-one clear.
module msi_cap_pending #(
   parameter int NUM_VEC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_vec,
   input  logic [NUM_VEC-1:0] clr_vec,
   output logic [NUM_VEC-1:0] pend
);
   for (genvar i = 0; i < NUM_VEC; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend[i] <= 1'b0;
         else if (set_vec[i]) pend[i] <= 1'b1;
         else if (clr_vec[i]) pend[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/msi_capture_ctrl.sv
`timescale 1ns/1ps
module msi_capture_ctrl #(
   parameter int NUM_VEC = 32,
   parameter int REG_W   = 32,
   parameter int DATA_W  = 32,
   parameter int N_IRQ   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_sel,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic                 msg_valid,
   input  logic [2*REG_W-1:0]   msg_addr,
   input  logic [DATA_W-1:0]    msg_data,
   output logic                 irq_a,
   output logic                 irq_b
);
   import msi_cap_pkg::*;

   localparam int ADDR_W = 2 * REG_W;

   if (NUM_VEC > REG_W) begin : g_bad_vec
      $error("NUM_VEC must fit in one register");
   end
   if (N_IRQ != 2) begin : g_bad_irq
      $error("N_IRQ must be 2 to match the port list");
   end
   if (ADDR_W != 64) begin : g_bad_addr
      $error("capture address must be 64 bits");
   end

   logic [REG_W-1:0]   cap_lo_q, cap_hi_q;
   logic [NUM_VEC-1:0] en_q, pend_q, set_vec, clr_vec;
   logic               irq_any;
   logic [N_IRQ-1:0]   irq_vec;

   msi_cap_regs #(.REG_W(REG_W), .NUM_VEC(NUM_VEC)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .cap_lo(cap_lo_q), .cap_hi(cap_hi_q), .en(en_q));

   msi_cap_match #(.REG_W(REG_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) match_i (
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
      .cap_lo(cap_lo_q), .cap_hi(cap_hi_q), .set_vec(set_vec));

   assign clr_vec = (reg_wr && reg_sel_e'(reg_sel) == SEL_PEND) ?
                    reg_wdata[NUM_VEC-1:0] : '0;

   msi_cap_pending #(.NUM_VEC(NUM_VEC)) pend_i (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend_q));

   always_comb begin
      reg_rdata = '0;
      case (reg_sel_e'(reg_sel))
         SEL_CAP_LO: reg_rdata = cap_lo_q;
         SEL_CAP_HI: reg_rdata = cap_hi_q;
         SEL_PEND:   reg_rdata[NUM_VEC-1:0] = pend_q;
         SEL_ENABLE: reg_rdata[NUM_VEC-1:0] = en_q;
         default:    reg_rdata = '0;
      endcase
   end

   assign irq_any = |(pend_q & en_q);
   for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
      assign irq_vec[k] = irq_any;
   end
   assign irq_a = irq_vec[0];
   assign irq_b = irq_vec[N_IRQ-1];
endmodule

// File: rtl/msi_cap_chk.sv
`timescale 1ns/1ps
module msi_cap_chk #(
   parameter int NUM_VEC = 32,
   parameter int REG_W   = 32,
   parameter int DATA_W  = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic [1:0]           reg_sel,
   input logic [REG_W-1:0]     reg_wdata,
   input logic                 msg_valid,
   input logic [2*REG_W-1:0]   msg_addr,
   input logic [DATA_W-1:0]    msg_data,
   input logic [REG_W-1:0]     cap_lo,
   input logic [REG_W-1:0]     cap_hi,
   input logic [NUM_VEC-1:0]   en,
   input logic [NUM_VEC-1:0]   pend,
   input logic                 irq_a,
   input logic                 irq_b
);
   localparam int IDX_W = $clog2(NUM_VEC);

   logic addr_ok, in_range, clr_wr;
   assign addr_ok  = msg_valid && cap_lo[0] && msg_addr[REG_W-1:0] == {cap_lo[REG_W-1:1], 1'b0}
                     && msg_addr[2*REG_W-1:REG_W] == cap_hi;
   assign in_range = msg_data < DATA_W'(NUM_VEC);
   assign clr_wr   = reg_wr && reg_sel == 2'd2;

   // R5 and R9: a matching arrival always leaves its flag set
   assert_arrival_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ok && in_range) |=> pend[$past(msg_data[IDX_W-1:0])]);

   // R2: written-one bits clear when nothing arrives
   assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !addr_ok) |=> (pend & $past(reg_wdata[NUM_VEC-1:0])) == '0);

   // R2: written-zero bits keep their value
   assert_w0_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !addr_ok) |=>
      (pend & ~$past(reg_wdata[NUM_VEC-1:0])) == ($past(pend) & ~$past(reg_wdata[NUM_VEC-1:0])));

   // R6 and R7: no set without an in-range matching arrival
   assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_ok && in_range) |=> (pend & ~$past(pend)) == '0);

   // R8: both lines carry the same value
   assert_twin_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a == irq_b);

   // R11: all masked means no interrupt
   assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq_a);
endmodule

bind msi_capture_ctrl msi_cap_chk #(.NUM_VEC(NUM_VEC), .REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
   .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
   .cap_lo(cap_lo_q), .cap_hi(cap_hi_q), .en(en_q), .pend(pend_q),
   .irq_a(irq_a), .irq_b(irq_b));

// File: tb/msi_capture_ctrl_tb.sv
`timescale 1ns/1ps
module msi_capture_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        msg_valid = 1'b0;
   logic [63:0] msg_addr = '0;
   logic [31:0] msg_data = '0;
   logic        irq_a, irq_b;

   int total = 0;
   int bad   = 0;
   logic [31:0] lo_m = '0, hi_m = '0, pend_m = '0, en_m = '0;

   always #2 clk = ~clk;

   msi_capture_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
      .irq_a(irq_a), .irq_b(irq_b));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic irq_exp();
      return |(pend_m & en_m);
   endfunction

   // One clock: the model applies clear before set so arrival wins (R9)
   task automatic step();
      logic hit;
      hit = msg_valid && lo_m[0] && msg_addr == {hi_m, lo_m[31:1], 1'b0} && msg_data < 32;
      @(posedge clk);
      if (reg_wr) begin
         case (reg_sel)
            2'd0: lo_m = reg_wdata;
            2'd1: hi_m = reg_wdata;
            2'd2: pend_m = pend_m & ~reg_wdata;
            default: en_m = reg_wdata;
         endcase
      end
      if (hit) pend_m[msg_data[4:0]] = 1'b1;
      #1;
      reg_wr = 1'b0;
      msg_valid = 1'b0;
      chk("R8 irq_a", {31'd0, irq_a}, {31'd0, irq_exp()});
      chk("R8 irq_b", {31'd0, irq_b}, {31'd0, irq_exp()});
   endtask

   task automatic wreg(input logic [1:0] s, input logic [31:0] d);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      step();
   endtask

   task automatic send(input logic [63:0] a, input logic [31:0] d);
      msg_valid = 1'b1; msg_addr = a; msg_data = d;
      step();
   endtask

   task automatic rd(input string tag, input logic [1:0] s, input logic [31:0] exp);
      reg_sel = s;
      #0.5;
      chk(tag, reg_rdata, exp);
   endtask

   localparam logic [63:0] BASE = 64'h0000_0012_ABCD_0100;

   initial begin
      void'($urandom(32'h5EED_1234));
      #9 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      rd("R1 lo reset", 2'd0, 32'h0);
      rd("R1 hi reset", 2'd1, 32'h0);
      rd("R1 pend reset", 2'd2, 32'h0);
      rd("R1 en reset", 2'd3, 32'h0);
      chk("R1 irq reset", {31'd0, irq_a | irq_b}, 32'h0);

      // R7: capture disabled, nothing latches
      wreg(2'd1, 32'h12);
      wreg(2'd0, 32'hABCD_0100);
      send(BASE, 32'd3);
      rd("R7 disabled", 2'd2, 32'h0);
      wreg(2'd0, 32'hABCD_0101);
      rd("R3 lo readback", 2'd0, 32'hABCD_0101);
      msg_valid = 1'b0; msg_addr = BASE; msg_data = 32'd3;
      step();
      rd("R7 valid low", 2'd2, 32'h0);

      // R5 and R10: masked arrival latches
      send(BASE, 32'd5);
      rd("R5 set bit5", 2'd2, 32'h20);
      chk("R10 masked irq", {31'd0, irq_a}, 32'h0);
      wreg(2'd3, 32'h20);
      chk("R10 irq after enable", {31'd0, irq_a}, 32'h1);

      // R4, R3, R6: rejected arrivals
      send(BASE ^ 64'h1_0000_0000, 32'd6);
      rd("R4 high mismatch", 2'd2, 32'h20);
      send(BASE | 64'h1, 32'd6);
      rd("R3 odd address", 2'd2, 32'h20);
      send(BASE, 32'd32);
      rd("R6 data 32", 2'd2, 32'h20);
      send(BASE, 32'hFFFF_FFFF);
      rd("R6 data max", 2'd2, 32'h20);
      send(BASE, 32'd31);
      rd("R5 set bit31", 2'd2, 32'h8000_0020);

      // R2: zero write keeps, one write clears
      wreg(2'd2, 32'h0);
      rd("R2 zero write", 2'd2, 32'h8000_0020);
      wreg(2'd2, 32'h20);
      rd("R2 clear bit5", 2'd2, 32'h8000_0000);
      chk("R2 irq dropped", {31'd0, irq_a}, 32'h0);

      // R9: clear and arrival on the same bit in one cycle
      send(BASE, 32'd7);
      reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h80;
      msg_valid = 1'b1; msg_addr = BASE; msg_data = 32'd7;
      step();
      rd("R9 arrival wins", 2'd2, 32'h8000_0080);

      // R11: disabling everything silences interrupts
      wreg(2'd3, 32'hFFFF_FFFF);
      chk("R8 irq all enabled", {31'd0, irq_a}, 32'h1);
      wreg(2'd3, 32'h0);
      chk("R11 irq off", {31'd0, irq_a}, 32'h0);
      rd("R11 en reads 0", 2'd3, 32'h0);

      // Random mix of clears, enables and arrivals
      for (int n = 0; n < 3000; n++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op < 2) begin
            reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = $urandom();
         end else if (op < 3) begin
            reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = $urandom();
         end
         if (op >= 1) begin
            msg_valid = 1'b1;
            msg_addr  = ($urandom_range(0, 3) != 0) ? BASE : BASE ^ (64'h1 << $urandom_range(0, 63));
            msg_data  = $urandom_range(0, 39);
         end
         step();
         if (n % 10 == 0) begin
            rd("R2 R5 R9 random pend", 2'd2, pend_m);
            rd("R1 random en", 2'd3, en_m);
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #800000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule